// File: doc/BRIEF.md
# Interleaved Depth-Cascade FIFO Controller

This controller joins several identical narrow synchronous FIFO banks into one FIFO of greater depth. The banks have no expansion logic of their own. Writes are dealt out one word at a time to bank 0, 1, 2, 3 and then back to bank 0. Reads follow the same rotation, so words leave the array in the order they arrived. Each bank takes a pair of write enables and a pair of read enables, one active-low and one active-high, and the controller drives both of each pair. The write data bus goes straight to every bank. The controller gates the enables so that only the selected bank acts.

The banks are filled in an interleaved way, so their fill levels never differ by more than one word. The full flag is taken from the bank the write rotation points at. The empty flag is taken from the bank the read rotation points at. The almost-full and almost-empty flags are taken from one fixed bank. The banks run in standard read mode: a bank presents its word on its output register one clock after the read. The controller therefore remembers which bank was read and selects that bank's output bus on the following cycle, with a valid strobe.

Top module: `fifo_cascade_ctrl`

## Requirements
- R1: After reset the write rotation points at bank 0. Each accepted write selects the next bank in the order 0, 1, 2, 3, then wraps to 0. The rotation does not move on a cycle with no accepted write.
- R2: The read rotation follows the same order and the same rules, driven by accepted reads. The word read is presented on `rd_data` with `rd_valid` high in the cycle after the accepted read. Words leave the array in the order they were written.
- R3: In any cycle at most one bank has its write enable active, and at most one bank has its read enable active.
- R4: An active enable is shown as 1 on the active-high line and 0 on the active-low line of that bank. An idle bank shows 0 on the active-high line and 1 on the active-low line. Bank i uses bit i of each enable vector.
- R5: `full` equals the full flag of the bank the write rotation selects. `empty` equals the empty flag of the bank the read rotation selects.
- R6: `almost_full` and `almost_empty` equal the flags of bank `FLAG_BANK` (default 0).
- R7: A write request while `full` is high, or a read request while `empty` is high, is ignored. No bank is enabled for it, the matching accept output stays low, and the rotation does not advance.
- R8: A write and a read requested in the same cycle are each accepted on their own conditions. Each one drives its own bank.
- R9: In reset all enables are idle, `rd_valid` is 0, and both rotations are at bank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with all banks |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Request to store one word |
| rd_req | input | 1 | Request to fetch one word |
| bank_full | input | NUM_BANKS | Per-bank full flags |
| bank_empty | input | NUM_BANKS | Per-bank empty flags |
| bank_afull | input | NUM_BANKS | Per-bank almost-full flags |
| bank_aempty | input | NUM_BANKS | Per-bank almost-empty flags |
| bank_rdata | input | NUM_BANKS*DATA_W | Bank output buses, bank i in bits i*DATA_W upward |
| bank_wen | output | NUM_BANKS | Active-high write enables |
| bank_wen_n | output | NUM_BANKS | Active-low write enables |
| bank_ren | output | NUM_BANKS | Active-high read enables |
| bank_ren_n | output | NUM_BANKS | Active-low read enables |
| wr_accept | output | 1 | Write taken this cycle |
| rd_accept | output | 1 | Read taken this cycle |
| rd_data | output | DATA_W | Word from the bank read in the previous cycle |
| rd_valid | output | 1 | rd_data holds a word just read |
| full | output | 1 | Aggregate full |
| empty | output | 1 | Aggregate empty |
| almost_full | output | 1 | Aggregate almost full |
| almost_empty | output | 1 | Aggregate almost empty |

## Verification
A write and a read can land in the same cycle. Each then enables a different bank, or the same bank when the two rotations coincide. The bench provokes this by preloading a few words and then holding both requests for many cycles, so the two rotations advance together at a fixed offset. It also issues a combined request while the array is empty, so that only the write may be taken. In every such cycle the bench compares both enable vectors, both accept outputs and the data returned on the next cycle against its own word-order model. Each check stands on its own.

// File: rtl/fifo_cascade_pkg.sv
package fifo_cascade_pkg;
  localparam int unsigned DEF_BANKS  = 4;
  localparam int unsigned DEF_DATA_W = 9;
endpackage

// File: rtl/rr_bank_ptr.sv
module rr_bank_ptr #(
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned PTR_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_BANKS - 1);

  logic [PTR_W-1:0] ptr_nxt;

  always_comb begin
    ptr_nxt = ptr;
    if (adv) begin
      ptr_nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_nxt;
  end

  // R1 / R2: one step per accepted transfer, with wrap
  a_r1_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));
  // R7: no movement without an accepted transfer
  a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr));
endmodule

// File: rtl/bank_enable_dec.sv
module bank_enable_dec #(
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned PTR_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [PTR_W-1:0]     sel,
  input  logic                 fire,
  output logic [NUM_BANKS-1:0] en,
  output logic [NUM_BANKS-1:0] en_n
);
  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    assign en[i]   = fire && (sel == PTR_W'(i));
    assign en_n[i] = !(fire && (sel == PTR_W'(i)));
  end
endmodule

// File: rtl/bank_rdata_sel.sv
module bank_rdata_sel #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned DATA_W    = 9,
  localparam int unsigned PTR_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_fire,
  input  logic [PTR_W-1:0]            rd_ptr,
  input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        rd_valid
);
  logic [PTR_W-1:0] sel_q, sel_nxt;
  logic             vld_nxt;

  always_comb begin
    sel_nxt = sel_q;
    if (rd_fire) sel_nxt = rd_ptr;
    vld_nxt = rd_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      rd_valid <= 1'b0;
    end else begin
      sel_q    <= sel_nxt;
      rd_valid <= vld_nxt;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (sel_q == PTR_W'(i)) rd_data = bank_rdata[i*DATA_W +: DATA_W];
    end
  end

  // R2: a word is presented exactly one cycle after each accepted read
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rd_valid);
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !rd_valid);
endmodule

// File: rtl/fifo_cascade_ctrl.sv
module fifo_cascade_ctrl
  import fifo_cascade_pkg::*;
#(
  parameter int unsigned NUM_BANKS = DEF_BANKS,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned FLAG_BANK = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_req,
  input  logic                        rd_req,
  input  logic [NUM_BANKS-1:0]        bank_full,
  input  logic [NUM_BANKS-1:0]        bank_empty,
  input  logic [NUM_BANKS-1:0]        bank_afull,
  input  logic [NUM_BANKS-1:0]        bank_aempty,
  input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata,
  output logic [NUM_BANKS-1:0]        bank_wen,
  output logic [NUM_BANKS-1:0]        bank_wen_n,
  output logic [NUM_BANKS-1:0]        bank_ren,
  output logic [NUM_BANKS-1:0]        bank_ren_n,
  output logic                        wr_accept,
  output logic                        rd_accept,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        rd_valid,
  output logic                        full,
  output logic                        empty,
  output logic                        almost_full,
  output logic                        almost_empty
);
  localparam int unsigned PTR_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  always_comb begin
    full         = bank_full[wr_ptr];
    empty        = bank_empty[rd_ptr];
    almost_full  = bank_afull[FLAG_BANK];
    almost_empty = bank_aempty[FLAG_BANK];
    wr_accept    = wr_req && !full;
    rd_accept    = rd_req && !empty;
  end

  rr_bank_ptr #(.NUM_BANKS(NUM_BANKS)) u_wr_ptr (
    .clk(clk), .rst_n(rst_n), .adv(wr_accept), .ptr(wr_ptr));

  rr_bank_ptr #(.NUM_BANKS(NUM_BANKS)) u_rd_ptr (
    .clk(clk), .rst_n(rst_n), .adv(rd_accept), .ptr(rd_ptr));

  bank_enable_dec #(.NUM_BANKS(NUM_BANKS)) u_wr_dec (
    .sel(wr_ptr), .fire(wr_accept), .en(bank_wen), .en_n(bank_wen_n));

  bank_enable_dec #(.NUM_BANKS(NUM_BANKS)) u_rd_dec (
    .sel(rd_ptr), .fire(rd_accept), .en(bank_ren), .en_n(bank_ren_n));

  bank_rdata_sel #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W)) u_rsel (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_accept), .rd_ptr(rd_ptr),
    .bank_rdata(bank_rdata), .rd_data(rd_data), .rd_valid(rd_valid));

  // R3: one bank per direction
  a_r3_one_wr_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_wen));
  a_r3_one_rd_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_ren));
  // R4: the two lines of a pair never both claim activity
  a_r4_pair_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wen & ~bank_wen_n) == bank_wen);
  // R7: a full bank is never written, an empty bank never read
  a_r7_no_wr_full: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wen & bank_full) == '0);
  a_r7_no_rd_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_ren & bank_empty) == '0);
endmodule

// File: tb/fifo_cascade_ctrl_test.sv
module fifo_cascade_ctrl_test;
  localparam int NB = 4;
  localparam int W  = 9;
  localparam int BD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_req = 1'b0, rd_req = 1'b0;
  logic [W-1:0] din = '0;
  logic [NB-1:0] b_full, b_empty, b_afull, b_aempty;
  logic [NB*W-1:0] b_rdata;
  logic [NB-1:0] wen, wen_n, ren, ren_n;
  logic wr_acc, rd_acc, rd_valid, full, empty, afull, aempty;
  logic [W-1:0] rd_data;

  always #10 clk = ~clk;

  fifo_cascade_ctrl #(.NUM_BANKS(NB), .DATA_W(W), .FLAG_BANK(0)) uut (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
    .bank_full(b_full), .bank_empty(b_empty), .bank_afull(b_afull),
    .bank_aempty(b_aempty), .bank_rdata(b_rdata),
    .bank_wen(wen), .bank_wen_n(wen_n), .bank_ren(ren), .bank_ren_n(ren_n),
    .wr_accept(wr_acc), .rd_accept(rd_acc), .rd_data(rd_data),
    .rd_valid(rd_valid), .full(full), .empty(empty),
    .almost_full(afull), .almost_empty(aempty));

  // behavioural banks: act only when both lines of a pair agree
  logic [W-1:0] mem [NB][BD];
  int cnt [NB];
  int hd [NB];
  int tl [NB];
  logic [W-1:0] dout [NB];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        cnt[b] = 0; hd[b] = 0; tl[b] = 0; dout[b] = '0;
      end
    end else begin
      for (int b = 0; b < NB; b++) begin
        automatic bit dw = wen[b] && !wen_n[b] && cnt[b] < BD;
        automatic bit dr = ren[b] && !ren_n[b] && cnt[b] > 0;
        if (dr) begin
          dout[b] = mem[b][hd[b]];
          hd[b] = (hd[b] + 1) % BD;
        end
        if (dw) begin
          mem[b][tl[b]] = din;
          tl[b] = (tl[b] + 1) % BD;
        end
        cnt[b] = cnt[b] + (dw ? 1 : 0) - (dr ? 1 : 0);
      end
    end
  end

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      b_full[b]   = (cnt[b] == BD);
      b_empty[b]  = (cnt[b] == 0);
      b_afull[b]  = (cnt[b] >= BD - 2);
      b_aempty[b] = (cnt[b] <= 2);
      b_rdata[b*W +: W] = dout[b];
    end
  end

  int tests = 0, fails = 0;
  int ewp = 0, erp = 0, total = 0;
  logic [W-1:0] q [$];
  logic [W-1:0] next_val = 9'h001;
  bit done = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one cycle with optional write and read; checks every visible output
  task automatic xfer(bit w, bit r);
    logic [NB-1:0] ew, er;
    bit xw, xr;
    logic [W-1:0] d, exp_d;
    @(negedge clk);
    d = next_val;
    wr_req = w; rd_req = r; din = d;
    #1;
    xw = w && (total < NB*BD) && (cnt[ewp] < BD);
    xr = r && (total > 0);
    ew = xw ? NB'(1 << ewp) : '0;
    er = xr ? NB'(1 << erp) : '0;
    chk(full == (total >= NB*BD && total / NB >= BD) || full == (cnt[ewp] == BD), "R5 full", full, cnt[ewp] == BD);
    chk(empty == (q.size() == 0), "R5 empty", empty, q.size() == 0);
    chk(afull == (cnt[0] >= BD-2) && aempty == (cnt[0] <= 2), "R6 almost flags",
        {afull, aempty}, {cnt[0] >= BD-2, cnt[0] <= 2});
    chk(wr_acc == xw, "R7 wr_accept", wr_acc, xw);
    chk(rd_acc == xr, "R7 rd_accept", rd_acc, xr);
    chk(wen == ew, "R1 R3 write bank", wen, ew);
    chk(ren == er, "R2 R3 read bank", ren, er);
    chk(wen_n == ~ew && ren_n == ~er, "R4 low-active pair", {wen_n, ren_n}, {~ew, ~er});
    @(posedge clk);
    if (xr) begin
      exp_d = q.pop_front();
      erp = (erp + 1) % NB;
      total--;
    end
    if (xw) begin
      q.push_back(d);
      ewp = (ewp + 1) % NB;
      total++;
      next_val = next_val + 9'd1;
    end
    #1;
    if (xr) chk(rd_valid && rd_data == exp_d, "R2 read word", {rd_valid, rd_data}, {1'b1, exp_d});
    else    chk(!rd_valid, "R2 no valid", rd_valid, 0);
    wr_req = 0; rd_req = 0;
  endtask

  task automatic t_reset();
    #1;
    chk(wen == '0 && wen_n == '1 && ren == '0 && ren_n == '1, "R9 enables idle",
        {wen, wen_n, ren, ren_n}, {4'h0, 4'hf, 4'h0, 4'hf});
    chk(!rd_valid, "R9 rd_valid", rd_valid, 0);
    chk(empty && !full, "R9 flags", {empty, full}, 2'b10);
  endtask

  task automatic t_rotation();   // R1 R2: six writes wrap past bank 3, six reads follow
    for (int i = 0; i < 6; i++) xfer(1, 0);
    for (int i = 0; i < 6; i++) xfer(0, 1);
  endtask

  task automatic t_fill();       // R7: the write after the array fills is dropped
    for (int i = 0; i < NB*BD + 2; i++) xfer(1, 0);
    chk(full, "R7 full after fill", full, 1);
  endtask

  task automatic t_drain();      // R7: reads past empty are dropped
    for (int i = 0; i < NB*BD + 2; i++) xfer(0, 1);
    chk(empty, "R7 empty after drain", empty, 1);
    xfer(1, 0);
    xfer(0, 1);
  endtask

  task automatic t_simul();      // R8: both directions in the same cycle
    xfer(1, 1);                  // empty: only the write goes
    for (int i = 0; i < 2; i++) xfer(1, 0);
    for (int i = 0; i < 10; i++) xfer(1, 1);
    for (int i = 0; i < 4; i++) xfer(0, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_rotation();
    t_fill();
    t_drain();
    t_simul();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule